// File: doc/BRIEF.md
# Miss and Write Buffer Allocation Controller

This block sits beside a cache controller and owns the bookkeeping of two small entry pools: one for outstanding misses and one for pending writes. Each incoming request is steered to one pool, given the lowest free entry there and stamped with a sequence number shared by both pools. Entries then move through three states: allocated (pending), in service once issued to memory, and free again when the response returns.

When a pool runs out of pending room, the controller sets that pool's bit in a mask of stall causes; a third bit is driven from outside for an entry that has run out of target slots. The CPU-side stall output and the per-cause statistics react only when the whole mask moves between empty and non-empty, so overlapping causes produce one stall episode. The block also raises a memory-side bus request after an allocation (or for a prefetch) unless the bus still owes a retry, and runs a loadable miss countdown that pulses once when it expires.

Top module: `miss_alloc_ctrl`

## Requirements
- R1: A request with the write flag set and the read flag clear goes to the write pool (alloc_pool = 1); every other request goes to the miss pool (alloc_pool = 0).
- R2: A miss-pool allocation reports the address rounded down to a multiple of BLK_BYTES and a size of BLK_BYTES; a write-pool allocation reports the request's address and size unchanged.
- R3: Successful allocations in either pool carry a sequence number that starts at 0 after reset and rises by exactly one per allocation.
- R4: A request takes the lowest-index entry that is not valid; if the pool has none, alloc_reject pulses instead of alloc_done and the sequence number does not advance.
- R5: A pool counts as full when every entry is valid and none is in service; an allocation that leaves its pool full sets blk_mask bit 0 (miss pool) or bit 1 (write pool); tgt_stall_set sets bit 2 and tgt_stall_clr clears it.
- R6: Marking an entry in service clears its pool's mask bit only when the pool was full before and is not full after; marking an entry that is invalid or already in service has no effect.
- R7: cpu_blocked rises only when blk_mask goes from zero to non-zero; at that edge the event counter of the setting cause (lowest bit if several set together) increments and the block start cycle is captured. Further causes added while blocked change no counter.
- R8: cpu_blocked falls only when blk_mask returns to zero; the elapsed clock edges since the block start are added to the blocked-cycle counter of the cause cleared last (highest bit if several clear together). Clearing one cause while another remains adds nothing.
- R9: A release frees an entry only if it is in service; releasing a pending or invalid entry has no effect.
- R10: mem_req_valid pulses one cycle after an allocation with req_bus set, with mem_req_cause equal to the pool index (0 miss, 1 write); without such an allocation, pf_bus_req raises it with cause 2. No request is raised in a cycle where bus_retry_pend is high.
- R11: A nonzero loaded miss limit decreases by one on each miss-pool allocation; miss_done pulses for one cycle when it reaches zero; a zero limit never pulses.
- R12: After reset the mask, cpu_blocked, all pulse outputs and every statistics counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request strobe |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | SIZE_W | Request size in bytes |
| req_rd | input | 1 | Request reads |
| req_wr | input | 1 | Request writes |
| req_bus | input | 1 | Raise a memory-side bus request on success |
| svc_valid | input | 1 | Mark an entry in service |
| svc_pool | input | 1 | Pool of the entry to mark (0 miss, 1 write) |
| svc_idx | input | IDX_W | Entry index to mark |
| rel_valid | input | 1 | Release an in-service entry |
| rel_pool | input | 1 | Pool of the entry to release |
| rel_idx | input | IDX_W | Entry index to release |
| tgt_stall_set | input | 1 | Set stall cause 2 (targets exhausted) |
| tgt_stall_clr | input | 1 | Clear stall cause 2 |
| pf_bus_req | input | 1 | Prefetch bus request |
| bus_retry_pend | input | 1 | Bus still owes a retry; suppress requests |
| lim_load | input | 1 | Load the miss limit |
| lim_value | input | LIM_W | Miss limit value |
| alloc_done | output | 1 | Allocation succeeded last cycle |
| alloc_reject | output | 1 | Allocation refused last cycle |
| alloc_pool | output | 1 | Pool of the allocation |
| alloc_idx | output | IDX_W | Entry index taken |
| alloc_seq | output | SEQ_W | Sequence number of the allocation |
| alloc_addr | output | ADDR_W | Address recorded in the entry |
| alloc_size | output | SIZE_W | Size recorded in the entry |
| blk_mask | output | 3 | Stall cause mask |
| cpu_blocked | output | 1 | CPU-side stall |
| mem_req_valid | output | 1 | Memory-side bus request pulse |
| mem_req_cause | output | 2 | Cause of the bus request |
| blk_events | output | 3*CNT_W | Stall episode count per cause, cause c at bits c*CNT_W |
| blk_cycles | output | 3*TS_W | Stalled cycles per cause, cause c at bits c*TS_W |
| miss_done | output | 1 | Miss limit reached pulse |

## Verification
Every result is registered once: the allocation record, mask, stall output, counters, bus request and limit pulse all reflect the inputs sampled at one rising edge and are valid right after it. The bench drives each stimulus for exactly one edge just after a falling edge and samples at the next falling edge, so each check lands one cycle after its cause. Stalled-cycle totals are predicted from a bench-side edge counter read at the check that saw the stall begin and at the check that saw it end.

// File: rtl/mac_pkg.sv
package mac_pkg;
   localparam int NUM_CAUSES = 3;
   localparam int CAUSE_W    = 2;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_MISS = 2'd0,
      CAUSE_WBUF = 2'd1,
      CAUSE_TGT  = 2'd2
   } cause_e;
endpackage

// File: rtl/mac_pool.sv
module mac_pool #(
   parameter int DEPTH = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_req,
   output logic             alloc_ok,
   output logic [IDX_W-1:0] alloc_idx,
   input  logic             svc_en,
   input  logic [IDX_W-1:0] svc_idx,
   input  logic             free_en,
   input  logic [IDX_W-1:0] free_idx,
   output logic             set_full,
   output logic             clr_full
);
   logic [DEPTH-1:0] vld_q, svc_q, vld_d, svc_d;
   logic [DEPTH-1:0] alloc_oh, svc_oh, free_oh;
   logic             found;
   logic [IDX_W-1:0] pick;
   logic             full_q, full_d;

   // lowest-index entry that is not valid
   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!vld_q[i]) begin
            found = 1'b1;
            pick  = IDX_W'(i);
         end
      end
   end

   assign alloc_ok  = alloc_req & found;
   assign alloc_idx = pick;

   for (genvar i = 0; i < DEPTH; i++) begin : g_dec
      assign alloc_oh[i] = alloc_ok && (pick == IDX_W'(i));
      assign svc_oh[i]   = svc_en && (svc_idx == IDX_W'(i)) && vld_q[i] && !svc_q[i];
      assign free_oh[i]  = free_en && (free_idx == IDX_W'(i)) && vld_q[i] && svc_q[i];
   end

   assign vld_d = (vld_q | alloc_oh) & ~free_oh;
   assign svc_d = (svc_q | svc_oh) & ~alloc_oh & ~free_oh;

   assign full_q = &(vld_q & ~svc_q);
   assign full_d = &(vld_d & ~svc_d);

   assign set_full = alloc_ok & full_d;
   assign clr_full = (|svc_oh) & full_q & ~full_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         svc_q <= '0;
      end else begin
         vld_q <= vld_d;
         svc_q <= svc_d;
      end
   end
endmodule

// File: rtl/mac_block_track.sv
module mac_block_track #(
   parameter int NC    = 3,
   parameter int CNT_W = 16,
   parameter int TS_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NC-1:0]     set_vec,
   input  logic [NC-1:0]     clr_vec,
   output logic [NC-1:0]     mask,
   output logic              blocked,
   output logic [NC*CNT_W-1:0] ev_flat,
   output logic [NC*TS_W-1:0]  cyc_flat
);
   localparam int CW = (NC > 1) ? $clog2(NC) : 1;

   logic [NC-1:0]   mask_q, mask_d;
   logic            rise, fall, blk_q;
   logic [CW-1:0]   set_c, clr_c;
   logic [TS_W-1:0] now_q, start_q;

   always_comb begin
      mask_d = (mask_q & ~clr_vec) | set_vec;
      rise   = (mask_q == '0) && (mask_d != '0);
      fall   = (mask_q != '0) && (mask_d == '0);
      set_c  = '0;
      for (int i = NC - 1; i >= 0; i--)
         if (set_vec[i]) set_c = CW'(i);
      clr_c  = '0;
      for (int i = 0; i < NC; i++)
         if (clr_vec[i] && mask_q[i]) clr_c = CW'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         blk_q   <= 1'b0;
         now_q   <= '0;
         start_q <= '0;
      end else begin
         mask_q <= mask_d;
         now_q  <= now_q + 1'b1;
         if (rise) begin
            blk_q   <= 1'b1;
            start_q <= now_q;
         end else if (fall) begin
            blk_q <= 1'b0;
         end
      end
   end

   for (genvar c = 0; c < NC; c++) begin : g_cause
      logic [CNT_W-1:0] ev_q;
      logic [TS_W-1:0]  acc_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ev_q  <= '0;
            acc_q <= '0;
         end else begin
            if (rise && set_c == CW'(c)) ev_q <= ev_q + 1'b1;
            if (fall && clr_c == CW'(c)) acc_q <= acc_q + (now_q - start_q);
         end
      end
      assign ev_flat[c*CNT_W +: CNT_W] = ev_q;
      assign cyc_flat[c*TS_W +: TS_W]  = acc_q;
   end

   assign mask    = mask_q;
   assign blocked = blk_q;
endmodule

// File: rtl/mac_miss_limit.sv
module mac_miss_limit #(
   parameter int LIM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LIM_W-1:0] value,
   input  logic             miss,
   output logic             done
);
   logic [LIM_W-1:0] left_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            left_q <= value;
         end else if (miss && left_q != '0) begin
            left_q <= left_q - 1'b1;
            done_q <= (left_q == LIM_W'(1));
         end
      end
   end

   assign done = done_q;
endmodule

// File: rtl/miss_alloc_ctrl.sv
module miss_alloc_ctrl
   import mac_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 8,
   parameter int BLK_BYTES  = 64,
   parameter int MISS_DEPTH = 4,
   parameter int WB_DEPTH   = 2,
   parameter int SEQ_W      = 16,
   parameter int CNT_W      = 16,
   parameter int TS_W       = 32,
   parameter int LIM_W      = 16,
   localparam int MAX_DEPTH = (MISS_DEPTH > WB_DEPTH) ? MISS_DEPTH : WB_DEPTH,
   localparam int IDX_W     = $clog2(MAX_DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [SIZE_W-1:0]          req_size,
   input  logic                       req_rd,
   input  logic                       req_wr,
   input  logic                       req_bus,
   input  logic                       svc_valid,
   input  logic                       svc_pool,
   input  logic [IDX_W-1:0]           svc_idx,
   input  logic                       rel_valid,
   input  logic                       rel_pool,
   input  logic [IDX_W-1:0]           rel_idx,
   input  logic                       tgt_stall_set,
   input  logic                       tgt_stall_clr,
   input  logic                       pf_bus_req,
   input  logic                       bus_retry_pend,
   input  logic                       lim_load,
   input  logic [LIM_W-1:0]           lim_value,
   output logic                       alloc_done,
   output logic                       alloc_reject,
   output logic                       alloc_pool,
   output logic [IDX_W-1:0]           alloc_idx,
   output logic [SEQ_W-1:0]           alloc_seq,
   output logic [ADDR_W-1:0]          alloc_addr,
   output logic [SIZE_W-1:0]          alloc_size,
   output logic [NUM_CAUSES-1:0]      blk_mask,
   output logic                       cpu_blocked,
   output logic                       mem_req_valid,
   output logic [CAUSE_W-1:0]         mem_req_cause,
   output logic [NUM_CAUSES*CNT_W-1:0] blk_events,
   output logic [NUM_CAUSES*TS_W-1:0]  blk_cycles,
   output logic                       miss_done
);
   localparam int OFF_W = $clog2(BLK_BYTES);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BLK_BYTES - 1);

   if (MISS_DEPTH < 2 || WB_DEPTH < 2) begin : g_bad_depth
      $error("pool depths must be at least 2");
   end
   if ((1 << OFF_W) != BLK_BYTES) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two");
   end
   if (BLK_BYTES >= (1 << SIZE_W)) begin : g_bad_size
      $error("SIZE_W too narrow for BLK_BYTES");
   end

   logic             to_wb;
   logic [1:0]       pool_req, pool_ok, pool_set, pool_clr;
   logic [IDX_W-1:0] pool_idx [2];
   logic             any_ok;

   assign to_wb       = req_wr & ~req_rd;
   assign pool_req[0] = req_valid & ~to_wb;
   assign pool_req[1] = req_valid & to_wb;

   for (genvar p = 0; p < 2; p++) begin : g_pool
      localparam int DEPTH = (p == 0) ? MISS_DEPTH : WB_DEPTH;
      mac_pool #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pool (
         .clk      (clk),
         .rst_n    (rst_n),
         .alloc_req(pool_req[p]),
         .alloc_ok (pool_ok[p]),
         .alloc_idx(pool_idx[p]),
         .svc_en   (svc_valid && (svc_pool == 1'(p))),
         .svc_idx  (svc_idx),
         .free_en  (rel_valid && (rel_pool == 1'(p))),
         .free_idx (rel_idx),
         .set_full (pool_set[p]),
         .clr_full (pool_clr[p])
      );
   end

   assign any_ok = |pool_ok;

   // allocation record and shared sequence
   logic [SEQ_W-1:0] seq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_q        <= '0;
         alloc_done   <= 1'b0;
         alloc_reject <= 1'b0;
         alloc_pool   <= 1'b0;
         alloc_idx    <= '0;
         alloc_seq    <= '0;
         alloc_addr   <= '0;
         alloc_size   <= '0;
      end else begin
         alloc_done   <= any_ok;
         alloc_reject <= req_valid & ~any_ok;
         if (any_ok) begin
            seq_q      <= seq_q + 1'b1;
            alloc_pool <= to_wb;
            alloc_idx  <= to_wb ? pool_idx[1] : pool_idx[0];
            alloc_seq  <= seq_q;
            alloc_addr <= to_wb ? req_addr : (req_addr & ALIGN_MASK);
            alloc_size <= to_wb ? req_size : SIZE_W'(BLK_BYTES);
         end
      end
   end

   // memory-side bus request
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_req_valid <= 1'b0;
         mem_req_cause <= '0;
      end else begin
         mem_req_valid <= ~bus_retry_pend & ((any_ok & req_bus) | pf_bus_req);
         if (any_ok & req_bus)
            mem_req_cause <= to_wb ? CAUSE_WBUF : CAUSE_MISS;
         else if (pf_bus_req)
            mem_req_cause <= CAUSE_TGT;
      end
   end

   mac_block_track #(.NC(NUM_CAUSES), .CNT_W(CNT_W), .TS_W(TS_W)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec ({tgt_stall_set, pool_set[1], pool_set[0]}),
      .clr_vec ({tgt_stall_clr, pool_clr[1], pool_clr[0]}),
      .mask    (blk_mask),
      .blocked (cpu_blocked),
      .ev_flat (blk_events),
      .cyc_flat(blk_cycles)
   );

   mac_miss_limit #(.LIM_W(LIM_W)) u_limit (
      .clk  (clk),
      .rst_n(rst_n),
      .load (lim_load),
      .value(lim_value),
      .miss (pool_ok[0]),
      .done (miss_done)
   );
endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
   parameter int ADDR_W    = 32,
   parameter int SIZE_W    = 8,
   parameter int BLK_BYTES = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_rd,
   input logic              req_wr,
   input logic              bus_retry_pend,
   input logic              alloc_done,
   input logic              alloc_reject,
   input logic              alloc_pool,
   input logic [ADDR_W-1:0] alloc_addr,
   input logic [SIZE_W-1:0] alloc_size,
   input logic [2:0]        blk_mask,
   input logic              cpu_blocked,
   input logic              mem_req_valid,
   input logic              miss_done
);
   localparam int OFF_W = $clog2(BLK_BYTES);

   p_steer_r1: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_done |-> alloc_pool == $past(req_wr && !req_rd));

   p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_done && !alloc_pool) |->
         (alloc_addr[OFF_W-1:0] == '0) && (alloc_size == SIZE_W'(BLK_BYTES)));

   p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(alloc_done && alloc_reject));

   p_rise_from_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_blocked) |-> ($past(blk_mask) == 3'b000) && (blk_mask != 3'b000));

   p_fall_to_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_blocked) |-> (blk_mask == 3'b000));

   p_retry_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !$past(bus_retry_pend));

   p_limit_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      miss_done |=> !miss_done);
endmodule

bind miss_alloc_ctrl mac_checker #(
   .ADDR_W   (ADDR_W),
   .SIZE_W   (SIZE_W),
   .BLK_BYTES(BLK_BYTES)
) u_mac_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_rd        (req_rd),
   .req_wr        (req_wr),
   .bus_retry_pend(bus_retry_pend),
   .alloc_done    (alloc_done),
   .alloc_reject  (alloc_reject),
   .alloc_pool    (alloc_pool),
   .alloc_addr    (alloc_addr),
   .alloc_size    (alloc_size),
   .blk_mask      (blk_mask),
   .cpu_blocked   (cpu_blocked),
   .mem_req_valid (mem_req_valid),
   .miss_done     (miss_done)
);

// File: tb/tb_miss_alloc_ctrl.sv
module tb_miss_alloc_ctrl;
   localparam int ADDR_W = 32, SIZE_W = 8, BLK = 64, SEQ_W = 16;
   localparam int CNT_W = 16, TS_W = 32, LIM_W = 16, IDX_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_rd = 0, req_wr = 0, req_bus = 0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [SIZE_W-1:0] req_size = '0;
   logic svc_valid = 0, svc_pool = 0, rel_valid = 0, rel_pool = 0;
   logic [IDX_W-1:0] svc_idx = '0, rel_idx = '0;
   logic tgt_stall_set = 0, tgt_stall_clr = 0, pf_bus_req = 0, bus_retry_pend = 0;
   logic lim_load = 0;
   logic [LIM_W-1:0] lim_value = '0;

   logic alloc_done, alloc_reject, alloc_pool, cpu_blocked, mem_req_valid, miss_done;
   logic [IDX_W-1:0] alloc_idx;
   logic [SEQ_W-1:0] alloc_seq;
   logic [ADDR_W-1:0] alloc_addr;
   logic [SIZE_W-1:0] alloc_size;
   logic [2:0] blk_mask;
   logic [1:0] mem_req_cause;
   logic [3*CNT_W-1:0] blk_events;
   logic [3*TS_W-1:0] blk_cycles;

   int checks = 0, fails = 0, edges = 0;
   int start_edge = 0;
   longint exp_c0 = 0, exp_c1 = 0;

   always #2 clk = ~clk;
   always @(posedge clk) edges++;

   miss_alloc_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
      .req_rd(req_rd), .req_wr(req_wr), .req_bus(req_bus),
      .svc_valid(svc_valid), .svc_pool(svc_pool), .svc_idx(svc_idx),
      .rel_valid(rel_valid), .rel_pool(rel_pool), .rel_idx(rel_idx),
      .tgt_stall_set(tgt_stall_set), .tgt_stall_clr(tgt_stall_clr),
      .pf_bus_req(pf_bus_req), .bus_retry_pend(bus_retry_pend),
      .lim_load(lim_load), .lim_value(lim_value),
      .alloc_done(alloc_done), .alloc_reject(alloc_reject), .alloc_pool(alloc_pool),
      .alloc_idx(alloc_idx), .alloc_seq(alloc_seq), .alloc_addr(alloc_addr),
      .alloc_size(alloc_size), .blk_mask(blk_mask), .cpu_blocked(cpu_blocked),
      .mem_req_valid(mem_req_valid), .mem_req_cause(mem_req_cause),
      .blk_events(blk_events), .blk_cycles(blk_cycles), .miss_done(miss_done)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint ev(input int c);
      return longint'(blk_events[c*CNT_W +: CNT_W]);
   endfunction
   function automatic longint cy(input int c);
      return longint'(blk_cycles[c*TS_W +: TS_W]);
   endfunction

   // one edge with the inputs set now, then clear pulses; caller checks after
   task automatic tick();
      @(negedge clk);
      req_valid = 0; req_rd = 0; req_wr = 0; req_bus = 0;
      svc_valid = 0; rel_valid = 0; tgt_stall_set = 0; tgt_stall_clr = 0;
      pf_bus_req = 0; bus_retry_pend = 0; lim_load = 0;
   endtask

   task automatic request(input logic [ADDR_W-1:0] a, input logic [SIZE_W-1:0] s,
                          input logic rd, input logic wr, input logic bus);
      req_valid = 1; req_addr = a; req_size = s; req_rd = rd; req_wr = wr; req_bus = bus;
      tick();
   endtask

   task automatic mark(input logic pool, input int idx);
      svc_valid = 1; svc_pool = pool; svc_idx = IDX_W'(idx);
      tick();
   endtask

   task automatic release_entry(input logic pool, input int idx);
      rel_valid = 1; rel_pool = pool; rel_idx = IDX_W'(idx);
      tick();
   endtask

   task automatic t_reset();
      check("R12 mask", blk_mask, 0);
      check("R12 blocked", cpu_blocked, 0);
      check("R12 done", alloc_done, 0);
      check("R12 memreq", mem_req_valid, 0);
      check("R12 ev0", ev(0), 0);
      check("R12 cyc1", cy(1), 0);
      check("R12 missdone", miss_done, 0);
   endtask

   task automatic t_steer();
      lim_load = 1; lim_value = 2; tick();
      request(32'h1234_5677, 4, 1, 0, 1);
      check("R1 pool read", alloc_pool, 0);
      check("R4 idx", alloc_idx, 0);
      check("R3 seq0", alloc_seq, 0);
      check("R2 aligned addr", alloc_addr, 32'h1234_5640);
      check("R2 block size", alloc_size, BLK);
      check("R10 req", mem_req_valid, 1);
      check("R10 cause miss", mem_req_cause, 0);
      check("R11 not yet", miss_done, 0);
      request(32'h0000_0ABC, 8, 0, 1, 1);
      check("R1 pool write", alloc_pool, 1);
      check("R3 seq1", alloc_seq, 1);
      check("R2 wb addr kept", alloc_addr, 32'h0000_0ABC);
      check("R2 wb size kept", alloc_size, 8);
      check("R10 cause wb", mem_req_cause, 1);
      request(32'h8000_007F, 2, 1, 1, 0);
      check("R1 rw to miss", alloc_pool, 0);
      check("R4 idx1", alloc_idx, 1);
      check("R3 seq2", alloc_seq, 2);
      check("R2 rw aligned", alloc_addr, 32'h8000_0040);
      check("R10 no bus flag", mem_req_valid, 0);
      check("R11 done pulse", miss_done, 1);
      tick();
      check("R11 pulse ends", miss_done, 0);
      check("R5 no stall yet", blk_mask, 0);
   endtask

   task automatic t_wb_block();
      request(32'h100, 4, 0, 1, 0);
      check("R4 wb idx1", alloc_idx, 1);
      check("R3 seq3", alloc_seq, 3);
      check("R5 wb full mask", blk_mask, 3'b010);
      check("R7 blocked rise", cpu_blocked, 1);
      check("R7 ev1", ev(1), 1);
      start_edge = edges;
      request(32'h200, 4, 0, 1, 0);
      check("R4 reject", alloc_reject, 1);
      check("R4 no done", alloc_done, 0);
      tick(); tick();
      mark(1, 0);
      exp_c1 += longint'(edges - start_edge);
      check("R6 clear bit1", blk_mask, 0);
      check("R8 blocked fall", cpu_blocked, 0);
      check("R8 cyc1", cy(1), exp_c1);
      mark(1, 0);
      check("R6 repeat mark ignored", blk_mask, 0);
      release_entry(1, 1);
      request(32'h300, 4, 0, 1, 0);
      check("R9 pending release ignored", alloc_reject, 1);
      release_entry(1, 0);
      request(32'h300, 4, 0, 1, 0);
      check("R9 freed entry reused", alloc_idx, 0);
      check("R3 seq4 after reject", alloc_seq, 4);
      check("R5 wb full again", blk_mask, 3'b010);
      check("R7 ev1 second", ev(1), 2);
      start_edge = edges;
      tick();
      mark(1, 1);
      exp_c1 += longint'(edges - start_edge);
      check("R8 cyc1 accum", cy(1), exp_c1);
   endtask

   task automatic t_multi();
      tgt_stall_set = 1; tick();
      check("R5 tgt bit", blk_mask, 3'b100);
      check("R7 rise tgt", cpu_blocked, 1);
      check("R7 ev2", ev(2), 1);
      start_edge = edges;
      request(32'h40, 4, 1, 0, 0);
      check("R4 idx2", alloc_idx, 2);
      check("R5 miss not full", blk_mask, 3'b100);
      request(32'hC0, 4, 1, 0, 0);
      check("R3 seq6", alloc_seq, 6);
      check("R5 miss full", blk_mask, 3'b101);
      check("R7 no ev0 while blocked", ev(0), 0);
      check("R11 limit spent", miss_done, 0);
      tgt_stall_clr = 1; tick();
      check("R8 partial clear", blk_mask, 3'b001);
      check("R8 still blocked", cpu_blocked, 1);
      check("R8 cyc2 untouched", cy(2), 0);
      mark(0, 3);
      exp_c0 += longint'(edges - start_edge);
      check("R8 fall", cpu_blocked, 0);
      check("R8 cyc0 last cleared", cy(0), exp_c0);
      check("R8 cyc2 zero", cy(2), 0);
   endtask

   task automatic t_bus();
      release_entry(0, 3);
      bus_retry_pend = 1;
      request(32'h1000, 4, 1, 0, 1);
      check("R4 idx3 reused", alloc_idx, 3);
      check("R10 retry blocks", mem_req_valid, 0);
      check("R5 refull", blk_mask, 3'b001);
      check("R7 ev0", ev(0), 1);
      pf_bus_req = 1; tick();
      check("R10 prefetch", mem_req_valid, 1);
      check("R10 prefetch cause", mem_req_cause, 2);
      pf_bus_req = 1; bus_retry_pend = 1; tick();
      check("R10 prefetch retry", mem_req_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_steer();
      t_wb_block();
      t_multi();
      t_bus();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #100000;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule